// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs single SPI flash transactions on behalf of software. Software writes a command byte, a count of bytes to send and a count of bytes to read back into byte-wide registers. It places the outgoing bytes in a shared byte buffer, then writes the start bit. The engine pulls chip select low and sends the command byte, then the outgoing bytes in buffer order. It then clocks in the requested number of reply bytes and releases chip select.

Reply bytes go into the same buffer. The first one lands at the index equal to the send count, so the outgoing data stays intact in front of the replies. Software polls a busy flag and then reads the replies back. A status word shows the data bytes completed, the buffer index the engine will write next and the buffer index it will read next.

The register port is a plain byte-wide write strobe with a registered read. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. The link uses SPI mode 0 with MSB first. SCK runs at the system clock divided by a parameter.

Top module: `sfce_top`

## Requirements
- R1: A write to offset 0x47 with data bit 7 set starts a transaction when the engine is idle. A write there with bit 7 clear starts nothing.
- R2: A start write made while the engine is busy is ignored. No second transaction follows, and the counts of the running one are unaffected.
- R3: The busy flag is bit 7 of the byte at offset 0x4F. It is set from the cycle after the start write until the transaction ends. Chip select (active low) is low for the whole transaction and high whenever the engine is idle.
- R4: The first byte on MOSI is the command byte from offset 0x45. It is followed by buffer entries 0 up to the send count (offset 0x48) minus one, in index order, each MSB first.
- R5: Reply bytes are sampled on the SCK rising edge and stored at buffer index send count + j for reply byte j, with the reply count taken from offset 0x4B. MOSI is 0 during reply bytes, and the entries that were sent are left unchanged.
- R6: The status word sits at byte offsets 0x4C to 0x4F. Byte 0x4C is the done count. Byte 0x4D holds the 7-bit write index, byte 0x4E holds the 7-bit read index, and bit 7 of byte 0x4F is busy.
- R7: The done count clears at start and rises by one after each sent or received data byte. The command byte does not count, so at the end it equals send count + reply count.
- R8: At start the read index is 0 and the write index equals the send count. Each sent byte advances the read index and each reply byte advances the write index.
- R9: SCK idles low. Each SCK half period lasts SCK_HALF_DIV system clocks, so a byte holds SCK high for 8*SCK_HALF_DIV clocks.
- R10: Reads return data one clock after the address is presented. The command and count registers read back as written, and buffer entry i is at offset 0x80+i.
- R11: Transfers at the limit work: send count equal to the buffer depth with no reply, and reply count equal to the depth with no send bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume software never asks for more send plus reply bytes than the buffer holds, and that it leaves the buffer alone while busy. The done-count bound and the index order depend on both. The stimulus draws the send count from 0 to the depth and the reply count from what is left. It writes the buffer only before the start bit and polls busy until clear before touching anything. A few directed cases cover the two limits, a start write with bit 7 clear and a second start issued mid-transfer.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
  localparam logic [7:0] OFS_OPCODE = 8'h45;
  localparam logic [7:0] OFS_START  = 8'h47;
  localparam logic [7:0] OFS_TXCNT  = 8'h48;
  localparam logic [7:0] OFS_RXCNT  = 8'h4B;
  localparam logic [7:0] OFS_STAT0  = 8'h4C;
  localparam logic [7:0] OFS_STAT1  = 8'h4D;
  localparam logic [7:0] OFS_STAT2  = 8'h4E;
  localparam logic [7:0] OFS_STAT3  = 8'h4F;
  localparam logic [7:0] BUF_BASE   = 8'h80;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_CLOSE} seq_state_t;
  typedef enum logic [1:0] {PH_CMD, PH_SEND, PH_RECV} phase_t;
endpackage

// File: rtl/sfce_buf_mem.sv
module sfce_buf_mem #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [7:0]       rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [7:0]       rd_data_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter #(
  parameter int HALF_DIV = 2,
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic             active;
  logic [CNT_W-1:0] div_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        tx_sr   <= tx_byte;
        div_cnt <= '0;
        bit_idx <= '0;
        sck     <= 1'b0;
      end else if (active) begin
        if (div_cnt == CNT_W'(HALF_DIV - 1)) begin
          div_cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + CNT_W'(1);
        end
      end
    end
  end

  assign mosi    = tx_sr[7];
  assign rx_byte = rx_sr;
endmodule

// File: rtl/sfce_seq.sv
module sfce_seq
  import sfce_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       send_cnt,
  input  logic [7:0]       recv_cnt,
  output logic [IDX_W-1:0] buf_rd_idx,
  input  logic [7:0]       buf_rd_data,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_wr_idx,
  output logic [7:0]       buf_wr_data,
  output logic             sh_start,
  output logic [7:0]       sh_byte,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             cs_n,
  output logic             busy,
  output logic [7:0]       done_cnt,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr
);
  seq_state_t st;
  phase_t     ph;
  logic [7:0] send_left, recv_left;
  logic [7:0] send_rem, recv_rem;

  assign send_rem = (ph == PH_SEND) ? send_left - 8'd1 : send_left;
  assign recv_rem = (ph == PH_RECV) ? recv_left - 8'd1 : recv_left;

  assign buf_rd_idx  = rd_ptr[IDX_W-1:0];
  assign buf_we      = (st == SQ_WAIT) && sh_done && (ph == PH_RECV);
  assign buf_wr_idx  = wr_ptr[IDX_W-1:0];
  assign buf_wr_data = sh_rx;
  assign busy        = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      ph        <= PH_CMD;
      send_left <= '0;
      recv_left <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      done_cnt  <= '0;
      sh_start  <= 1'b0;
      sh_byte   <= '0;
      cs_n      <= 1'b1;
    end else begin
      sh_start <= 1'b0;
      unique case (st)
        SQ_IDLE: if (go) begin
          st        <= SQ_ISSUE;
          ph        <= PH_CMD;
          send_left <= send_cnt;
          recv_left <= recv_cnt;
          rd_ptr    <= '0;
          wr_ptr    <= send_cnt[PTR_W-1:0];
          done_cnt  <= '0;
          cs_n      <= 1'b0;
        end
        SQ_ISSUE: begin
          sh_start <= 1'b1;
          unique case (ph)
            PH_CMD:  sh_byte <= cmd_byte;
            PH_SEND: sh_byte <= buf_rd_data;
            default: sh_byte <= 8'h00;
          endcase
          st <= SQ_WAIT;
        end
        SQ_WAIT: if (sh_done) begin
          if (ph == PH_SEND) begin
            rd_ptr    <= rd_ptr + PTR_W'(1);
            send_left <= send_rem;
            done_cnt  <= done_cnt + 8'd1;
          end else if (ph == PH_RECV) begin
            wr_ptr    <= wr_ptr + PTR_W'(1);
            recv_left <= recv_rem;
            done_cnt  <= done_cnt + 8'd1;
          end
          if (ph != PH_RECV && send_rem != 8'd0) begin
            ph <= PH_SEND;
            st <= SQ_ISSUE;
          end else if (recv_rem != 8'd0) begin
            ph <= PH_RECV;
            st <= SQ_ISSUE;
          end else begin
            st <= SQ_CLOSE;
          end
        end
        default: begin
          cs_n <= 1'b1;
          st   <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sfce_top.sv
module sfce_top
  import sfce_pkg::*;
#(
  parameter int FIFO_DEPTH   = 64,
  parameter int SCK_HALF_DIV = 2,
  localparam int IDX_W = $clog2(FIFO_DEPTH),
  localparam int PTR_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr_en,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]       cmd_q, send_q, recv_q;
  logic [7:0]       buf_ofs;
  logic             in_buf;
  logic             go;
  logic             eng_busy;
  logic [7:0]       done_cnt;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [IDX_W-1:0] eng_rd_idx, eng_wr_idx, mem_wr_idx;
  logic [7:0]       eng_rd_data, eng_wr_data, mem_wr_data, sw_rd_data;
  logic             eng_we, mem_we;
  logic             sh_start, sh_done;
  logic [7:0]       sh_byte, sh_rx;

  assign buf_ofs = bus_addr - BUF_BASE;
  assign in_buf  = (bus_addr >= BUF_BASE) && (buf_ofs < 8'(FIFO_DEPTH));
  assign go      = bus_wr_en && (bus_addr == OFS_START) && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      send_q <= '0;
      recv_q <= '0;
    end else if (bus_wr_en) begin
      if (bus_addr == OFS_OPCODE) cmd_q  <= bus_wdata;
      if (bus_addr == OFS_TXCNT)  send_q <= bus_wdata;
      if (bus_addr == OFS_RXCNT)  recv_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        OFS_OPCODE: bus_rdata <= cmd_q;
        OFS_TXCNT:  bus_rdata <= send_q;
        OFS_RXCNT:  bus_rdata <= recv_q;
        OFS_STAT0:  bus_rdata <= done_cnt;
        OFS_STAT1:  bus_rdata <= {1'b0, 7'(wr_ptr)};
        OFS_STAT2:  bus_rdata <= {1'b0, 7'(rd_ptr)};
        OFS_STAT3:  bus_rdata <= {eng_busy, 7'b0};
        default:    bus_rdata <= in_buf ? sw_rd_data : 8'h00;
      endcase
    end
  end

  assign mem_we      = eng_we || (bus_wr_en && in_buf);
  assign mem_wr_idx  = eng_we ? eng_wr_idx : buf_ofs[IDX_W-1:0];
  assign mem_wr_data = eng_we ? eng_wr_data : bus_wdata;

  sfce_buf_mem #(.DEPTH(FIFO_DEPTH)) u_mem (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_idx    (mem_wr_idx),
    .wr_data   (mem_wr_data),
    .rd_idx_a  (eng_rd_idx),
    .rd_data_a (eng_rd_data),
    .rd_idx_b  (buf_ofs[IDX_W-1:0]),
    .rd_data_b (sw_rd_data)
  );

  sfce_seq #(.DEPTH(FIFO_DEPTH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .cmd_byte    (cmd_q),
    .send_cnt    (send_q),
    .recv_cnt    (recv_q),
    .buf_rd_idx  (eng_rd_idx),
    .buf_rd_data (eng_rd_data),
    .buf_we      (eng_we),
    .buf_wr_idx  (eng_wr_idx),
    .buf_wr_data (eng_wr_data),
    .sh_start    (sh_start),
    .sh_byte     (sh_byte),
    .sh_done     (sh_done),
    .sh_rx       (sh_rx),
    .cs_n        (spi_cs_n),
    .busy        (eng_busy),
    .done_cnt    (done_cnt),
    .rd_ptr      (rd_ptr),
    .wr_ptr      (wr_ptr)
  );

  sfce_shifter #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_byte),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );
endmodule

// File: rtl/sfce_checker.sv
module sfce_checker #(
  parameter int FIFO_DEPTH = 64,
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr_en,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             spi_cs_n,
  input logic             spi_sck,
  input logic             eng_busy,
  input logic [7:0]       done_cnt,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] wr_ptr
);
  logic start_wr;
  assign start_wr = bus_wr_en && (bus_addr == 8'h47) && bus_wdata[7];

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && start_wr) |=> eng_busy);

  p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !start_wr) |=> !eng_busy);

  p_retrigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && start_wr) |=> (done_cnt >= $past(done_cnt)));

  p_cs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> spi_cs_n);

  p_sck_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_done_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> (done_cnt == $past(done_cnt) || done_cnt == 8'($past(done_cnt) + 8'd1)));

  p_done_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= 8'(FIFO_DEPTH));

  p_ptr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= wr_ptr);
endmodule

bind sfce_top sfce_checker #(.FIFO_DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_sfce_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .eng_busy  (eng_busy),
  .done_cnt  (done_cnt),
  .rd_ptr    (rd_ptr),
  .wr_ptr    (wr_ptr)
);

// File: tb/sfce_top_bench.sv
module sfce_top_bench;
  localparam int DEPTH = 64;
  localparam int HALF  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sfce_top #(.FIFO_DEPTH(DEPTH), .SCK_HALF_DIV(HALF)) u_sfce_top (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // serial device model
  logic [7:0] salt = 8'h00;
  logic [7:0] seen [0:DEPTH+1];
  int         seen_n = 0;
  int         cs_falls = 0;
  int         s_bit = 0;
  int         s_byte = 0;
  logic [7:0] s_out = 8'h00;
  logic [7:0] s_in = 8'h00;
  int         sck_hi = 0;

  function automatic logic [7:0] reply(logic [7:0] s, int k);
    return 8'((s * 7) + (k * 29) + 8'h5A) ^ 8'(k);
  endfunction

  always @(negedge spi_cs_n) begin
    cs_falls = cs_falls + 1;
    s_bit = 0; s_byte = 0; seen_n = 0;
    s_out = reply(salt, 0);
  end
  always @(posedge spi_sck) begin
    s_in = {s_in[6:0], spi_mosi};
    s_bit = s_bit + 1;
    if (s_bit == 8) begin
      if (s_byte <= DEPTH + 1) seen[s_byte] = s_in;
      s_byte = s_byte + 1;
      seen_n = s_byte;
      s_bit = 0;
    end
  end
  always @(negedge spi_sck) begin
    if (s_bit == 0) s_out = reply(salt, s_byte);
    else s_out = {s_out[6:0], 1'b0};
  end
  assign spi_miso = s_out[7];

  always @(posedge clk) if (spi_sck) sck_hi <= sck_hi + 1;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_read(8'h4F, v);
      if (!v[7]) return;
    end
    check("R3 busy never cleared", 1, 0);
  endtask

  logic [7:0] tx_data [0:DEPTH-1];

  task automatic run_txn(logic [7:0] op, int tx, int rx, bit retrig);
    logic [7:0] v;
    int falls0, bad;
    for (int i = 0; i < tx; i++) tx_data[i] = 8'($urandom);
    bus_write(8'h45, op);
    bus_write(8'h48, 8'(tx));
    bus_write(8'h4B, 8'(rx));
    for (int i = 0; i < tx; i++) bus_write(8'h80 + 8'(i), tx_data[i]);
    salt = 8'($urandom);
    falls0 = cs_falls;
    sck_hi = 0;
    bus_write(8'h47, 8'h80);
    bus_read(8'h4F, v);
    check("R3 busy after start", int'(v[7]), 1);
    if (retrig) begin
      bus_write(8'h48, 8'(tx));
      bus_write(8'h47, 8'hFF);
    end
    wait_idle();
    check("R3/R2 one chip-select cycle", cs_falls - falls0, 1);
    check("R3 cs high when idle", int'(spi_cs_n), 1);
    check("R9 sck high clocks", sck_hi, (1 + tx + rx) * 8 * HALF);
    check("R4 bytes on link", seen_n, 1 + tx + rx);
    check("R4 command byte", int'(seen[0]), int'(op));
    bad = 0;
    for (int i = 0; i < tx; i++) if (seen[1+i] !== tx_data[i]) bad++;
    check("R4 send bytes in order", bad, 0);
    bad = 0;
    for (int j = 0; j < rx; j++) if (seen[1+tx+j] !== 8'h00) bad++;
    check("R5 mosi low in replies", bad, 0);
    bad = 0;
    for (int j = 0; j < rx; j++) begin
      bus_read(8'h80 + 8'(tx + j), v);
      if (v !== reply(salt, 1 + tx + j)) bad++;
    end
    check("R5 replies at offset", bad, 0);
    bad = 0;
    for (int i = 0; i < tx; i++) begin
      bus_read(8'h80 + 8'(i), v);
      if (v !== tx_data[i]) bad++;
    end
    check("R5 sent entries kept", bad, 0);
    bus_read(8'h4C, v); check("R7 done count", int'(v), tx + rx);
    bus_read(8'h4D, v); check("R8 write index", int'(v), tx + rx);
    bus_read(8'h4E, v); check("R8 read index", int'(v), tx);
    bus_read(8'h4F, v); check("R6 busy byte idle", int'(v), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state
    bus_read(8'h4C, v); check("R6 reset done", int'(v), 0);
    bus_read(8'h4D, v); check("R6 reset wr idx", int'(v), 0);
    bus_read(8'h4F, v); check("R6 reset busy", int'(v), 0);
    check("R3 reset cs", int'(spi_cs_n), 1);
    check("R9 reset sck", int'(spi_sck), 0);
    // R10 readback
    bus_write(8'h45, 8'h9F); bus_write(8'h48, 8'h03); bus_write(8'h4B, 8'h05);
    bus_read(8'h45, v); check("R10 cmd readback", int'(v), 8'h9F);
    bus_read(8'h48, v); check("R10 send cnt readback", int'(v), 3);
    bus_read(8'h4B, v); check("R10 recv cnt readback", int'(v), 5);
    bus_write(8'h80 + 8'd63, 8'hA5);
    bus_read(8'h80 + 8'd63, v); check("R10 buffer last entry", int'(v), 8'hA5);
    // R1 start with bit 7 clear
    f0 = cs_falls;
    bus_write(8'h47, 8'h7F);
    repeat (4) @(negedge clk);
    bus_read(8'h4F, v); check("R1 no start bit7 clear", int'(v), 0);
    check("R1 no chip select", cs_falls - f0, 0);
    // directed corners
    run_txn(8'h05, 0, 0, 1'b0);
    run_txn(8'h02, DEPTH, 0, 1'b0);    // R11
    run_txn(8'h03, 0, DEPTH, 1'b0);    // R11
    run_txn(8'h0B, 4, 6, 1'b1);        // R2 retrigger mid-transfer
    for (int t = 0; t < 10; t++) begin
      int tx, rx;
      tx = int'($urandom % (DEPTH + 1));
      rx = int'($urandom % (DEPTH + 1 - tx));
      run_txn(8'($urandom), tx, rx, 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule